// File: doc/BRIEF.md
# Writeback Slot Allocator

This block manages a short calendar of future writeback cycles. Each of its D rows stands for one upcoming clock. Each row has W ports. Finished instructions ask for a place in the calendar. Each one is given the earliest free port, searching first by cycle and then by port. When a cycle has no free port left, the search moves on to the next cycle.

Every clock the calendar moves forward by one row. The row at the head is presented to the writeback side and then freed. Each head entry is forwarded towards commit. It also raises a wakeup, and marks its destination register ready, but only when it is valid for that: not cancelled, actually executed, and free of any fault. Three statistics are kept for each thread: how many entries were written back, how many of them produced a value, and how many consumers those producers had.

Up to NREQ requests can arrive in the same clock. They are placed one after another in index order. Each request sees the slots already taken by the requests with a lower index.

Top module: `wb_slot_alloc`

## Requirements
- R1: After reset the calendar is empty: no head port is valid, no wakeup or ready bit is raised, and all per-thread counters read zero.
- R2: A request granted at relative cycle r (`req_cyc`) and port p (`req_port`) in some clock appears on head port p, with its tag and thread, exactly r rising edges later.
- R3: A request is placed in the lowest free flat position cycle×W+port, with the search starting at relative cycle 1, port 0. Ports within a cycle are taken lowest first. The search spills into the next cycle only when all W ports of a cycle are occupied.
- R4: Requests in the same clock are served in index order. Invalid requests are skipped. Each valid request avoids every slot granted to a lower-index request in that clock.
- R5: Relative cycles 1..D-1 bound the calendar, so it holds at most (D-1)×W entries. A valid request that finds no free slot sees `req_gnt` low. Once a valid request is refused, every higher-index request in that clock is refused too.
- R6: The head row is read in port order, and `hd_valid` is a run of ones from port 0. The head row is empty after the clock edge that passes it, so its slots can be granted again.
- R7: `hd_wake[p]` is high only for a valid head entry that is not squashed, has executed, and has no fault.
- R8: `rdy_set[d]` is high exactly when some waking head entry has its destination enable set and destination register d.
- R9: A head entry that does not wake (squashed, unexecuted or faulted) is still presented with `hd_valid` high, with its tag and thread.
- R10: For each thread, at every edge, `wb_cnt` rises by the number of valid head entries of that thread. `prod_cnt` rises by the number of waking entries. `cons_cnt` rises by the sum of those waking entries' dependent counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Completion request per lane |
| req_tag | input | NREQ×TAGW | Instruction tag per lane |
| req_thr | input | NREQ×TW | Thread of each request |
| req_dst | input | NREQ×RW | Destination register index |
| req_dst_en | input | NREQ | Destination register present |
| req_squashed | input | NREQ | Entry was cancelled |
| req_executed | input | NREQ | Entry has executed |
| req_fault | input | NREQ | Entry carries a fault |
| req_ndep | input | NREQ×DEPW | Number of dependents |
| req_gnt | output | NREQ | Slot granted this clock |
| req_cyc | output | NREQ×CW | Relative cycle of granted slot (1..D-1) |
| req_port | output | NREQ×PTW | Port of granted slot |
| hd_valid | output | W | Head entry forwarded to commit |
| hd_tag | output | W×TAGW | Head entry tag |
| hd_thr | output | W×TW | Head entry thread |
| hd_wake | output | W | Wakeup pulse per head port |
| rdy_set | output | NREG | Ready bits to set in the scoreboard |
| prod_cnt | output | NTHR×CNTW | Producers per thread |
| cons_cnt | output | NTHR×CNTW | Consumers per thread |
| wb_cnt | output | NTHR×CNTW | Writebacks per thread |

## Verification
In one clock, new requests claim rows 1..D-1 while the head row is read, counted and cleared. The old head row then becomes the farthest row in the calendar. The bench provokes this overlap by issuing three requests per clock for several clocks against a calendar of six slots. This keeps the calendar full, so a refused request, the freeing of the head and new grants all happen together. A behavioural model that keeps absolute cycle numbers predicts each grant position, each head entry, its wake gating, the ready mask and the counters. The model is compared on every clock.

// File: rtl/wbsa_pkg.sv
package wbsa_pkg;

   typedef struct packed {
      logic squashed;
      logic executed;
      logic fault;
   } wbsa_flags_t;

   function automatic logic wbsa_can_wake(input wbsa_flags_t f);
      return !f.squashed && f.executed && !f.fault;
   endfunction

endpackage

// File: rtl/wbsa_slot_search.sv
module wbsa_slot_search #(
   parameter int NSLOT = 6,
   parameter int NREQ  = 3,
   parameter int SW    = 3
) (
   input  logic [NSLOT-1:0]          occ,
   input  logic [NREQ-1:0]           req_valid,
   output logic [NREQ-1:0]           gnt,
   output logic [NREQ-1:0][SW-1:0]   idx
);

   logic [NSLOT-1:0] taken;
   logic             hit;

   // chained lowest-free search, lane order
   always_comb begin
      taken = occ;
      gnt   = '0;
      idx   = '0;
      hit   = 1'b0;
      for (int i = 0; i < NREQ; i++) begin
         hit = 1'b0;
         for (int k = 0; k < NSLOT; k++) begin
            if (req_valid[i] && !hit && !taken[k]) begin
               hit    = 1'b1;
               gnt[i] = 1'b1;
               idx[i] = SW'(k);
            end
         end
         if (gnt[i]) taken[idx[i]] = 1'b1;
      end
   end

endmodule

// File: rtl/wbsa_head_read.sv
module wbsa_head_read import wbsa_pkg::*; #(
   parameter int W    = 2,
   parameter int NREG = 16,
   parameter int RW   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [W-1:0]              row_v,
   input  wbsa_flags_t [W-1:0]       row_flg,
   input  logic [W-1:0][RW-1:0]      row_dst,
   input  logic [W-1:0]              row_den,
   output logic [W-1:0]              live,
   output logic [W-1:0]              wake,
   output logic [NREG-1:0]           rdy_set
);

   logic run;

   always_comb begin
      run     = 1'b1;
      live    = '0;
      wake    = '0;
      rdy_set = '0;
      for (int p = 0; p < W; p++) begin
         run     = run & row_v[p];
         live[p] = run;
         wake[p] = run & wbsa_can_wake(row_flg[p]);
         if (wake[p] && row_den[p]) rdy_set[row_dst[p]] = 1'b1;
      end
   end

   // R8
   rdy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rdy_set) <= $countones(wake));

endmodule

// File: rtl/wbsa_thread_stats.sv
module wbsa_thread_stats #(
   parameter int W    = 2,
   parameter int NTHR = 2,
   parameter int TW   = 1,
   parameter int DEPW = 3,
   parameter int CNTW = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [W-1:0]                live,
   input  logic [W-1:0]                wake,
   input  logic [W-1:0][TW-1:0]        thr,
   input  logic [W-1:0][DEPW-1:0]      ndep,
   output logic [NTHR-1:0][CNTW-1:0]   prod_cnt,
   output logic [NTHR-1:0][CNTW-1:0]   cons_cnt,
   output logic [NTHR-1:0][CNTW-1:0]   wb_cnt
);

   logic [NTHR-1:0][CNTW-1:0] prod_n, cons_n, wb_n;

   always_comb begin
      prod_n = prod_cnt;
      cons_n = cons_cnt;
      wb_n   = wb_cnt;
      for (int p = 0; p < W; p++) begin
         if (live[p]) begin
            wb_n[thr[p]] = wb_n[thr[p]] + 1'b1;
            if (wake[p]) begin
               prod_n[thr[p]] = prod_n[thr[p]] + 1'b1;
               cons_n[thr[p]] = cons_n[thr[p]] + CNTW'(ndep[p]);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_cnt <= '0;
         cons_cnt <= '0;
         wb_cnt   <= '0;
      end else begin
         prod_cnt <= prod_n;
         cons_cnt <= cons_n;
         wb_cnt   <= wb_n;
      end
   end

   for (genvar t = 0; t < NTHR; t++) begin : g_chk
      // R10
      wb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         CNTW'(wb_cnt[t] - $past(wb_cnt[t])) <= CNTW'(W));
      // R10
      prod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         CNTW'(prod_cnt[t] - $past(prod_cnt[t])) <= CNTW'(wb_cnt[t] - $past(wb_cnt[t])));
   end

endmodule

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc import wbsa_pkg::*; #(
   parameter int W     = 2,
   parameter int D     = 4,
   parameter int NREQ  = 3,
   parameter int NTHR  = 2,
   parameter int NREG  = 16,
   parameter int TAGW  = 8,
   parameter int DEPW  = 3,
   parameter int CNTW  = 16,
   localparam int TW    = (NTHR > 1) ? $clog2(NTHR) : 1,
   localparam int RW    = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int CW    = (D > 1) ? $clog2(D) : 1,
   localparam int PTW   = (W > 1) ? $clog2(W) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NREQ-1:0]             req_valid,
   input  logic [NREQ-1:0][TAGW-1:0]   req_tag,
   input  logic [NREQ-1:0][TW-1:0]     req_thr,
   input  logic [NREQ-1:0][RW-1:0]     req_dst,
   input  logic [NREQ-1:0]             req_dst_en,
   input  logic [NREQ-1:0]             req_squashed,
   input  logic [NREQ-1:0]             req_executed,
   input  logic [NREQ-1:0]             req_fault,
   input  logic [NREQ-1:0][DEPW-1:0]   req_ndep,
   output logic [NREQ-1:0]             req_gnt,
   output logic [NREQ-1:0][CW-1:0]     req_cyc,
   output logic [NREQ-1:0][PTW-1:0]    req_port,
   output logic [W-1:0]                hd_valid,
   output logic [W-1:0][TAGW-1:0]      hd_tag,
   output logic [W-1:0][TW-1:0]        hd_thr,
   output logic [W-1:0]                hd_wake,
   output logic [NREG-1:0]             rdy_set,
   output logic [NTHR-1:0][CNTW-1:0]   prod_cnt,
   output logic [NTHR-1:0][CNTW-1:0]   cons_cnt,
   output logic [NTHR-1:0][CNTW-1:0]   wb_cnt
);

   localparam int NSLOT = (D - 1) * W;
   localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
   localparam int PW    = CW;

   // elaboration-time parameter checks
   if (D < 2 || (D & (D - 1)) != 0) begin : g_bad_depth
      $error("wb_slot_alloc: D must be a power of two, at least 2");
   end
   if (W < 1 || NREQ < 1 || NTHR < 1) begin : g_bad_width
      $error("wb_slot_alloc: W, NREQ and NTHR must be positive");
   end
   if (DEPW > CNTW) begin : g_bad_cnt
      $error("wb_slot_alloc: counters narrower than dependent count");
   end

   // calendar storage
   logic [PW-1:0]                     hp;
   logic [D-1:0][W-1:0]               e_v;
   logic [D-1:0][W-1:0][TAGW-1:0]     e_tag;
   logic [D-1:0][W-1:0][TW-1:0]       e_thr;
   logic [D-1:0][W-1:0][RW-1:0]       e_dst;
   logic [D-1:0][W-1:0]               e_den;
   wbsa_flags_t [D-1:0][W-1:0]        e_flg;
   logic [D-1:0][W-1:0][DEPW-1:0]     e_nd;

   logic [D-1:0][PW-1:0]              rel_row;
   logic [NSLOT-1:0]                  occ;
   logic [NREQ-1:0][SW-1:0]           slot_idx;
   logic [NREQ-1:0][PW-1:0]           wr_row;
   logic [NREQ-1:0][PTW-1:0]          wr_port;

   // flatten future rows into search order
   always_comb begin
      occ = '0;
      for (int r = 0; r < D; r++) rel_row[r] = hp + PW'(r);
      for (int r = 1; r < D; r++)
         for (int p = 0; p < W; p++)
            occ[(r - 1) * W + p] = e_v[rel_row[r]][p];
   end

   wbsa_slot_search #(.NSLOT(NSLOT), .NREQ(NREQ), .SW(SW)) u_search (
      .occ       (occ),
      .req_valid (req_valid),
      .gnt       (req_gnt),
      .idx       (slot_idx)
   );

   always_comb begin
      for (int i = 0; i < NREQ; i++) begin
         req_cyc[i]  = CW'(int'(slot_idx[i]) / W + 1);
         req_port[i] = PTW'(int'(slot_idx[i]) % W);
         wr_row[i]   = hp + PW'(int'(slot_idx[i]) / W + 1);
         wr_port[i]  = PTW'(int'(slot_idx[i]) % W);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hp  <= '0;
         e_v <= '0;
      end else begin
         e_v[hp] <= '0;
         for (int i = 0; i < NREQ; i++)
            if (req_gnt[i]) e_v[wr_row[i]][wr_port[i]] <= 1'b1;
         hp <= hp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREQ; i++) begin
         if (req_gnt[i]) begin
            e_tag[wr_row[i]][wr_port[i]] <= req_tag[i];
            e_thr[wr_row[i]][wr_port[i]] <= req_thr[i];
            e_dst[wr_row[i]][wr_port[i]] <= req_dst[i];
            e_den[wr_row[i]][wr_port[i]] <= req_dst_en[i];
            e_flg[wr_row[i]][wr_port[i]] <= '{squashed: req_squashed[i],
                                              executed: req_executed[i],
                                              fault:    req_fault[i]};
            e_nd[wr_row[i]][wr_port[i]]  <= req_ndep[i];
         end
      end
   end

   // head row
   wbsa_head_read #(.W(W), .NREG(NREG), .RW(RW)) u_head (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_v   (e_v[hp]),
      .row_flg (e_flg[hp]),
      .row_dst (e_dst[hp]),
      .row_den (e_den[hp]),
      .live    (hd_valid),
      .wake    (hd_wake),
      .rdy_set (rdy_set)
   );

   assign hd_tag = e_tag[hp];
   assign hd_thr = e_thr[hp];

   wbsa_thread_stats #(.W(W), .NTHR(NTHR), .TW(TW), .DEPW(DEPW), .CNTW(CNTW)) u_stats (
      .clk      (clk),
      .rst_n    (rst_n),
      .live     (hd_valid),
      .wake     (hd_wake),
      .thr      (e_thr[hp]),
      .ndep     (e_nd[hp]),
      .prod_cnt (prod_cnt),
      .cons_cnt (cons_cnt),
      .wb_cnt   (wb_cnt)
   );

   // R6
   row_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_v[hp] & (e_v[hp] + 1'b1)) == '0);
   // R6
   head_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      e_v[$past(hp)] == '0);
   // R5
   capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_gnt) <= NSLOT - $countones(occ));

   for (genvar i = 0; i < NREQ; i++) begin : g_lane_chk
      // R4
      no_clobber_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_gnt[i] |-> !occ[slot_idx[i]]);
      if (i < NREQ - 1) begin : g_order
         // R5
         refuse_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && !req_gnt[i]) |-> (req_gnt[NREQ-1:i+1] == '0));
      end
      for (genvar j = i + 1; j < NREQ; j++) begin : g_pair
         // R4
         distinct_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_gnt[i] && req_gnt[j]) |-> (slot_idx[i] != slot_idx[j]));
      end
   end

endmodule

// File: tb/wb_slot_alloc_bench.sv
module wb_slot_alloc_bench;

   localparam int W = 2, D = 4, NREQ = 3, NTHR = 2, NREG = 16;
   localparam int TAGW = 8, DEPW = 3, CNTW = 16;
   localparam int TW = 1, RW = 4, CW = 2, PTW = 1;
   localparam int MR = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NREQ-1:0]             req_valid;
   logic [NREQ-1:0][TAGW-1:0]   req_tag;
   logic [NREQ-1:0][TW-1:0]     req_thr;
   logic [NREQ-1:0][RW-1:0]     req_dst;
   logic [NREQ-1:0]             req_dst_en, req_squashed, req_executed, req_fault;
   logic [NREQ-1:0][DEPW-1:0]   req_ndep;
   logic [NREQ-1:0]             req_gnt;
   logic [NREQ-1:0][CW-1:0]     req_cyc;
   logic [NREQ-1:0][PTW-1:0]    req_port;
   logic [W-1:0]                hd_valid, hd_wake;
   logic [W-1:0][TAGW-1:0]      hd_tag;
   logic [W-1:0][TW-1:0]        hd_thr;
   logic [NREG-1:0]             rdy_set;
   logic [NTHR-1:0][CNTW-1:0]   prod_cnt, cons_cnt, wb_cnt;

   always #4 clk = ~clk;

   wb_slot_alloc #(.W(W), .D(D), .NREQ(NREQ), .NTHR(NTHR), .NREG(NREG),
                   .TAGW(TAGW), .DEPW(DEPW), .CNTW(CNTW)) u_wb_slot_alloc (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
      .req_thr(req_thr), .req_dst(req_dst), .req_dst_en(req_dst_en),
      .req_squashed(req_squashed), .req_executed(req_executed),
      .req_fault(req_fault), .req_ndep(req_ndep), .req_gnt(req_gnt),
      .req_cyc(req_cyc), .req_port(req_port), .hd_valid(hd_valid),
      .hd_tag(hd_tag), .hd_thr(hd_thr), .hd_wake(hd_wake), .rdy_set(rdy_set),
      .prod_cnt(prod_cnt), .cons_cnt(cons_cnt), .wb_cnt(wb_cnt));

   int total = 0, fails = 0, k = 0;
   bit done = 0;
   logic [31:0] seed = 32'h1bad_5eed;

   // behavioural model indexed by absolute cycle
   bit   mv  [MR][W];
   int   mtag[MR][W], mthr[MR][W], mdst[MR][W], mden[MR][W];
   int   msq [MR][W], mex [MR][W], mflt[MR][W], mnd [MR][W];
   int   ewb[NTHR], eprod[NTHR], econs[NTHR];

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   task automatic chk(input string rq, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s slot %0d: actual=%0h expected=%0h", rq, k, act, exp);
      end
   endtask

   task automatic do_slot(input logic [NREQ-1:0] vm);
      int eg, ecyc, eport, row, fr;
      bit any_g, run, ew;
      logic [NREG-1:0] erdy;
      string lbl;
      for (int i = 0; i < NREQ; i++) begin
         logic [31:0] r;
         r = rnd();
         req_valid[i]    = vm[i];
         req_tag[i]      = TAGW'(k * 4 + i);
         req_thr[i]      = r[0];
         req_dst[i]      = r[4:1];
         req_dst_en[i]   = r[5];
         req_squashed[i] = (r[10:8] == 3'd0);
         req_executed[i] = (r[13:11] != 3'd0);
         req_fault[i]    = (r[16:14] == 3'd7);
         req_ndep[i]     = r[19:17];
      end
      #1;
      // counters reflect heads of earlier slots (R10)
      for (int t = 0; t < NTHR; t++) begin
         chk("R10", wb_cnt[t],   ewb[t]   & 32'hFFFF);
         chk("R10", prod_cnt[t], eprod[t] & 32'hFFFF);
         chk("R10", cons_cnt[t], econs[t] & 32'hFFFF);
      end
      // grants
      any_g = 0;
      for (int i = 0; i < NREQ; i++) begin
         eg = 0; ecyc = 0; eport = 0;
         if (vm[i])
            for (int s = 1; s < D; s++)
               for (int p = 0; p < W; p++)
                  if (eg == 0 && !mv[(k + s) % MR][p]) begin
                     eg = 1; ecyc = s; eport = p;
                  end
         lbl = (vm[i] && eg == 0) ? "R5" : (any_g ? "R4" : "R3");
         chk(lbl, req_gnt[i], eg);
         if (eg != 0) begin
            chk(lbl, req_cyc[i], ecyc);
            chk(lbl, req_port[i], eport);
            fr = (k + ecyc) % MR;
            mv[fr][eport]   = 1;
            mtag[fr][eport] = int'(req_tag[i]);
            mthr[fr][eport] = int'(req_thr[i]);
            mdst[fr][eport] = int'(req_dst[i]);
            mden[fr][eport] = int'(req_dst_en[i]);
            msq[fr][eport]  = int'(req_squashed[i]);
            mex[fr][eport]  = int'(req_executed[i]);
            mflt[fr][eport] = int'(req_fault[i]);
            mnd[fr][eport]  = int'(req_ndep[i]);
            any_g = 1;
         end
      end
      // head row
      row = k % MR;
      run = 1;
      erdy = '0;
      for (int p = 0; p < W; p++) begin
         run = run && mv[row][p];
         chk("R6", hd_valid[p], run);
         ew = run && msq[row][p] == 0 && mex[row][p] != 0 && mflt[row][p] == 0;
         chk("R7", hd_wake[p], ew);
         if (run) begin
            chk("R2", hd_tag[p], mtag[row][p]);
            chk("R2", hd_thr[p], mthr[row][p]);
            if (!ew) chk("R9", hd_valid[p], 1);
            ewb[mthr[row][p]]++;
            if (ew) begin
               eprod[mthr[row][p]]++;
               econs[mthr[row][p]] += mnd[row][p];
               if (mden[row][p] != 0) erdy[mdst[row][p]] = 1'b1;
            end
         end
      end
      chk("R8", rdy_set, erdy);
      for (int p = 0; p < W; p++) mv[row][p] = 0;
      k++;
      @(negedge clk);
   endtask

   initial begin
      req_valid = '0; req_tag = '0; req_thr = '0; req_dst = '0;
      req_dst_en = '0; req_squashed = '0; req_executed = '0;
      req_fault = '0; req_ndep = '0;
      for (int r = 0; r < MR; r++)
         for (int p = 0; p < W; p++) mv[r][p] = 0;
      for (int t = 0; t < NTHR; t++) begin ewb[t] = 0; eprod[t] = 0; econs[t] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: empty after reset
      chk("R1", hd_valid, 0);
      chk("R1", hd_wake, 0);
      chk("R1", rdy_set, 0);
      for (int t = 0; t < NTHR; t++) chk("R1", wb_cnt[t] | prod_cnt[t] | cons_cnt[t], 0);
      // single request, then drain (R2 timing)
      do_slot(3'b001);
      repeat (5) do_slot(3'b000);
      // sustained overload: capacity and refusals with head freeing (R5, R6)
      repeat (10) do_slot(3'b111);
      repeat (5) do_slot(3'b000);
      // gaps in lane validity (R4)
      repeat (4) begin
         do_slot(3'b101); do_slot(3'b010); do_slot(3'b110);
         do_slot(3'b011); do_slot(3'b000);
      end
      // random traffic
      repeat (300) do_slot(NREQ'(rnd()));
      repeat (6) do_slot(3'b000);
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule